// File: doc/BRIEF.md
# Clock Manager Reset Supervisor

This block produces the reset for an on-chip clock-management unit and tells downstream logic when that unit's output clocks can be used. When the chip comes out of its configuration reset, the block issues a reset pulse of fixed length. The pulse comes from a shift register loaded with a run of ones that are shifted out one per cycle.

After that pulse, the supervisor watches three conditions from the managed unit:

- the lock flag;
- a status bit that reports the input clock has stopped;
- a status bit that reports the synthesized clocks have stopped.

If any of them shows a failure, the supervisor reloads the shift register and reset goes out again. The synthesized-clock condition counts only when the design uses those outputs. A separate input says whether the input clock is stable yet, and reset is held for as long as that input is low.

All monitored inputs pass through two-flop synchronizers before they are evaluated. Each re-issued reset adds one to a saturating event counter. The clocks-valid output goes high only when three things hold: no reset is being driven, the synchronized lock flag is high, and the input clock is stable.

Top module: `clkmgr_rst_sup`

## Requirements
- R1: After `rstN` is released, `mgrReset` stays high for exactly four cycles, counting the cycle in which `rstN` rises, and then goes low, provided `inClkStable` is high.
- R2: `clocksValid` is never high while the synchronized lock flag is low. It follows `lockIn` with a latency of two clock edges when no reset is driven and the input clock is stable.
- R3: If the synchronized lock flag falls after it was high outside a reset pulse, `mgrReset` rises on the third clock edge after `lockIn` falls and stays high for four cycles.
- R4: While `mgrStatus[1]` (input clock stopped) is 1, a reset pulse of four cycles is issued. `mgrReset` rises on the third clock edge after the bit goes high.
- R5: `mgrStatus[2]` (synthesized clocks stopped) triggers the same four-cycle pulse, but only when `synthUsed` is 1. When `synthUsed` is 0, the bit has no effect on `mgrReset` or `rstCount`.
- R6: While the synchronized `inClkStable` is 0, `mgrReset` is high and `clocksValid` is low. This hold does not reload the pulse and does not change `rstCount`.
- R7: `rstCount` is 0 after `rstN` and increases by one for each re-triggered pulse. The power-on pulse does not count.
- R8: `rstCount` saturates at its all-ones value (15 for the default width).
- R9: If the lock flag is low and has not been high since the last pulse, no pulse is re-triggered, so the supervisor does not loop on a unit that is still acquiring lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rstN | input | 1 | Active-low configuration reset; loads the power-on pulse |
| lockIn | input | 1 | Lock flag from the managed unit (asynchronous) |
| mgrStatus | input | 2 | Bit 1 = input clock stopped, bit 2 = synthesized clocks stopped (asynchronous) |
| inClkStable | input | 1 | High once the managed unit's input clock is stable (asynchronous) |
| synthUsed | input | 1 | High when the synthesized outputs are used by the design |
| mgrReset | output | 1 | Reset to the managed unit, active high |
| clocksValid | output | 1 | Managed clocks may be used |
| rstCount | output | 4 | Saturating count of re-triggered resets |

## Verification
A shift register that was preloaded wrongly, or a reload on the wrong cycle, shows up at once as a reset pulse of the wrong length. Every pulse is therefore timed edge by edge. A fault in the lock-seen state shows up in one of two ways. Either there is no pulse after a real loss of lock, or pulses repeat endlessly while the unit has never locked; the second case shows within a few cycles of any pulse. Mistakes in the synchronizer depth move each reaction by one or more edges, so every trigger is checked both at its expected edge and at the edge before it.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef struct packed {
    logic reload;   // restart the reset pulse
    logic bump;     // count one re-triggered reset
  } crs_strobe_t;
endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else if (s == 0) chain[s] <= din;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/crs_datapath.sv
module crs_datapath
  import crs_pkg::*;
#(
  parameter int SR_W      = 16,
  parameter int PULSE_LEN = 4,
  parameter int CNT_W     = 4,
  parameter int SYNC_N    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  crs_strobe_t       strobes,
  input  logic              lockIn,
  input  logic [2:1]        mgrStatus,
  input  logic              inClkStable,
  output logic              lockSync,
  output logic              inStop,
  output logic              fxStop,
  output logic              stableSync,
  output logic              pulseActive,
  output logic [CNT_W-1:0]  rstCount
);
  localparam logic [SR_W-1:0]  PRELOAD = SR_W'((1 << PULSE_LEN) - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [3:0]       syncOut;
  logic [SR_W-1:0]  pulseSr;
  logic [CNT_W-1:0] evCount;

  crs_sync #(.WIDTH(4), .STAGES(SYNC_N)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({inClkStable, mgrStatus[2], mgrStatus[1], lockIn}),
    .dout(syncOut)
  );

  assign lockSync   = syncOut[0];
  assign inStop     = syncOut[1];
  assign fxStop     = syncOut[2];
  assign stableSync = syncOut[3];

  // power-on pattern shifts out ones, then zeros
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseSr <= PRELOAD;
    else if (strobes.reload) pulseSr <= PRELOAD;
    else pulseSr <= pulseSr >> 1;
  end

  assign pulseActive = pulseSr[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evCount <= '0;
    else if (strobes.bump && evCount != CNT_MAX) evCount <= evCount + 1'b1;
  end

  assign rstCount = evCount;

  AST_RELOAD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reload |=> pulseActive) else $error("reload without pulse"); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.bump && evCount != CNT_MAX) |=> evCount == CNT_W'($past(evCount) + 1)) else $error("count step"); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (evCount == CNT_MAX) |=> evCount == CNT_MAX) else $error("count wrapped"); // R8
endmodule

// File: rtl/crs_control.sv
module crs_control
  import crs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lockSync,
  input  logic        inStop,
  input  logic        fxStop,
  input  logic        synthUsed,
  input  logic        pulseActive,
  output crs_strobe_t strobes
);
  logic lockSeen;
  logic lockLost;
  logic failNow;

  assign lockLost = lockSeen && !lockSync;
  assign failNow  = lockLost || inStop || (fxStop && synthUsed);

  always_comb begin
    strobes        = '0;
    strobes.reload = !pulseActive && failNow;
    strobes.bump   = strobes.reload;
  end

  // lock counts as achieved only outside a pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockSeen <= 1'b0;
    else if (strobes.reload) lockSeen <= 1'b0;
    else if (!pulseActive && lockSync) lockSeen <= 1'b1;
  end

  AST_NO_LOOP_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!lockSeen && !inStop && !fxStop) |-> !strobes.reload) else $error("retrigger without cause"); // R9
  AST_LOSS_RETRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    (lockSeen && !lockSync && !pulseActive) |=> pulseActive) else $error("lock loss ignored"); // R3
endmodule

// File: rtl/clkmgr_rst_sup.sv
module clkmgr_rst_sup
  import crs_pkg::*;
#(
  parameter int SR_W      = 16,
  parameter int PULSE_LEN = 4,
  parameter int CNT_W     = 4,
  parameter int SYNC_N    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lockIn,
  input  logic [2:1]       mgrStatus,
  input  logic             inClkStable,
  input  logic             synthUsed,
  output logic             mgrReset,
  output logic             clocksValid,
  output logic [CNT_W-1:0] rstCount
);
  crs_strobe_t strobes;
  logic lockSync, inStop, fxStop, stableSync, pulseActive;

  crs_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lockSync   (lockSync),
    .inStop     (inStop),
    .fxStop     (fxStop),
    .synthUsed  (synthUsed),
    .pulseActive(pulseActive),
    .strobes    (strobes)
  );

  crs_datapath #(.SR_W(SR_W), .PULSE_LEN(PULSE_LEN), .CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .lockIn     (lockIn),
    .mgrStatus  (mgrStatus),
    .inClkStable(inClkStable),
    .lockSync   (lockSync),
    .inStop     (inStop),
    .fxStop     (fxStop),
    .stableSync (stableSync),
    .pulseActive(pulseActive),
    .rstCount   (rstCount)
  );

  assign mgrReset    = pulseActive || !stableSync;
  assign clocksValid = !mgrReset && lockSync;

  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    clocksValid |-> lockSync) else $error("valid without lock"); // R2
  AST_STABLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stableSync |-> (mgrReset && !clocksValid)) else $error("unstable not held"); // R6
  AST_FX_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!synthUsed && !pulseActive && $stable(rstCount) && !inStop) |=> !pulseActive || $past(lockSync) == 1'b0) else $error("fx stop acted"); // R5
endmodule

// File: tb/sim_clkmgr_rst_sup.sv
module sim_clkmgr_rst_sup;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lockIn = 1'b0;
  logic [2:1] mgrStatus = '0;
  logic inClkStable = 1'b1;
  logic synthUsed = 1'b0;
  logic mgrReset, clocksValid;
  logic [3:0] rstCount;

  int checks = 0;
  int failures = 0;
  int expCount = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  clkmgr_rst_sup u0 (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .mgrStatus(mgrStatus),
    .inClkStable(inClkStable), .synthUsed(synthUsed),
    .mgrReset(mgrReset), .clocksValid(clocksValid), .rstCount(rstCount)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts negedges with mgrReset high, starting at the current one
  task automatic pulseLen(output int n);
    n = 0;
    while (mgrReset && n < 50) begin n++; @(negedge clk); end
  endtask

  task automatic testPowerOn();
    int n;
    cyc(3);
    check(mgrReset == 1 && clocksValid == 0, "R1 reset state outputs", mgrReset, 1);
    check(rstCount == 0, "R7 reset count", rstCount, 0);
    rstN = 1'b1;
    pulseLen(n);
    check(n == 4, "R1 power-on pulse length", n, 4);
    cyc(10);
    check(mgrReset == 0, "R9 no retrigger before lock", mgrReset, 0);
    check(rstCount == 0, "R7 power-on not counted", rstCount, 0);
  endtask

  task automatic testValid();
    lockIn = 1'b1;
    cyc(1);
    check(clocksValid == 0, "R2 valid not before two edges", clocksValid, 0);
    cyc(1);
    check(clocksValid == 1, "R2 valid after lock", clocksValid, 1);
  endtask

  task automatic testLockLoss();
    int n;
    cyc(3);
    lockIn = 1'b0;
    cyc(2);
    check(clocksValid == 0, "R2 valid drops with lock", clocksValid, 0);
    check(mgrReset == 0, "R3 reset not early", mgrReset, 0);
    cyc(1);
    check(mgrReset == 1, "R3 reset after lock loss", mgrReset, 1);
    pulseLen(n);
    expCount++;
    check(n == 4, "R3 re-trigger pulse length", n, 4);
    check(rstCount == expCount, "R7 count after lock loss", rstCount, expCount);
    cyc(10);
    check(mgrReset == 0, "R9 no loop while unlocked", mgrReset, 0);
  endtask

  task automatic testInStop(input bit timed);
    int n;
    mgrStatus[1] = 1'b1;
    if (timed) begin
      cyc(2);
      check(mgrReset == 0, "R4 reset not early", mgrReset, 0);
      cyc(1);
      check(mgrReset == 1, "R4 reset on input stop", mgrReset, 1);
    end else begin
      cyc(3);
    end
    mgrStatus[1] = 1'b0;
    pulseLen(n);
    if (expCount < 15) expCount++;
    if (timed) check(n == 4, "R4 pulse length", n, 4);
    cyc(3);
  endtask

  task automatic testFxStop();
    int n;
    synthUsed = 1'b0;
    mgrStatus[2] = 1'b1;
    cyc(8);
    check(mgrReset == 0, "R5 fx stop ignored when unused", mgrReset, 0);
    check(rstCount == expCount, "R5 count unchanged when unused", rstCount, expCount);
    synthUsed = 1'b1;
    cyc(1);
    check(mgrReset == 1, "R5 fx stop acts when used", mgrReset, 1);
    mgrStatus[2] = 1'b0;
    pulseLen(n);
    expCount++;
    check(n == 4, "R5 pulse length", n, 4);
    check(rstCount == expCount, "R5 count", rstCount, expCount);
    synthUsed = 1'b0;
    cyc(3);
  endtask

  task automatic testStable();
    lockIn = 1'b1;
    cyc(4);
    check(clocksValid == 1, "R6 valid before unstable", clocksValid, 1);
    inClkStable = 1'b0;
    cyc(2);
    check(mgrReset == 1 && clocksValid == 0, "R6 hold while unstable", mgrReset, 1);
    cyc(5);
    check(mgrReset == 1, "R6 still held", mgrReset, 1);
    inClkStable = 1'b1;
    cyc(2);
    check(mgrReset == 0 && clocksValid == 1, "R6 release after stable", mgrReset, 0);
    check(rstCount == expCount, "R6 count unchanged", rstCount, expCount);
    lockIn = 1'b0;
    cyc(3);
    while (mgrReset) @(negedge clk);
    expCount++;
    cyc(3);
  endtask

  task automatic testSaturate();
    for (int i = 0; i < 18; i++) testInStop(1'b0);
    check(rstCount == 15, "R8 saturated count", rstCount, 15);
  endtask

  initial begin
    #(PERIOD * 50000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    testPowerOn();
    testValid();
    testLockLoss();
    testInStop(1'b1);
    check(rstCount == expCount, "R7 count after input stop", rstCount, expCount);
    testFxStop();
    testStable();
    check(rstCount == expCount, "R7 count after stable test", rstCount, expCount);
    testSaturate();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule